// File: doc/BRIEF.md
# Pixel Overlap Collision Latches

This block watches six one-bit serial graphics streams (playfield, player 0, player 1, missile 0, missile 1 and ball). On every clock where pixel output is enabled, it checks every pair of streams for overlap. The six streams form fifteen distinct pairs. Each pair has its own sticky flag. The flag sets when both members of the pair are high on an enabled pixel, and it stays set until a single shared clear strobe wipes all fifteen flags at once.

Software reads the flags through a narrow register port. Each read address reports two flags, one on data bit 7 and one on data bit 6. Data bits 5 down to 0 are always zero. An address that selects no register returns zero on every bit. The read result is registered: it appears on the cycle after the read strobe and holds until the next strobe.

Top module: `collisionLatchArray`

## Requirements
- R1: Stream positions on `gfxBits` are fixed: bit 0 playfield, bit 1 player 0, bit 2 player 1, bit 3 missile 0, bit 4 missile 1, bit 5 ball. Pairs (i,j) with i<j are numbered k = 0..14 in order of increasing i, then increasing j. For example, (0,1) is k=0, (1,2) is k=5 and (4,5) is k=14.
- R2: At a clock edge where `pixEn` is high and both streams of pair k are high, flag k becomes 1.
- R3: At a clock edge where `pixEn` is low, no flag changes from 0 to 1, whatever the streams carry.
- R4: A set flag stays set across later cycles until a clear. Flags set on different cycles accumulate.
- R5: A clock edge with `clrAll` high makes all fifteen flags 0.
- R6: When a clear and a set fall on the same edge, the clear wins and every flag ends up 0.
- R7: At a clock edge with `rdStrobe` high and `rdAddr` = a < 8, `rdData` takes flag 2a on bit 7 and flag 2a+1 on bit 6. The bit 6 position of address 7 has no flag and reads 0. The read captures the flag state from before that edge, and `rdData` holds its value while `rdStrobe` is low.
- R8: Bits 5 down to 0 of `rdData` are always 0.
- R9: A strobed read of any address of 8 or more returns 0 on all bits.
- R10: While reset is asserted, all flags and `rdData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gfxBits | input | 6 | Serial graphics stream bits, one per source |
| pixEn | input | 1 | Pixel enable; overlap detection happens only while this is high |
| clrAll | input | 1 | Clears every collision flag |
| rdAddr | input | ADDR_W (4) | Read register address |
| rdStrobe | input | 1 | Read request; captures the addressed flags into `rdData` |
| rdData | output | 8 | Registered read data; only bits 7 and 6 carry flags |

## Verification
Three things can land on the same clock edge: a new overlap setting flags, the shared clear, and a read capturing flags. The bench forces all six streams high with both `pixEn` and `clrAll` asserted on one edge, then reads every address and expects all zeros. It also strobes a read on the very edge that sets a flag. That read must return the pre-edge state, and the next read must show the new flag. Around these collisions, all 64 stream patterns are swept one at a time, each followed by a full readout of all sixteen addresses. Each readout is compared with pair products computed in the bench.

// File: rtl/collPkg.sv
package collPkg;
  localparam int NUM_SRC   = 6;
  localparam int NUM_PAIRS = NUM_SRC * (NUM_SRC - 1) / 2;
  localparam int NUM_REGS  = (NUM_PAIRS + 1) / 2;
  localparam int SEL_W     = $clog2(NUM_REGS);
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic setEn;
    logic clrAll;
    logic rdLoad;
    logic rdMapped;
  } collStrobes_t;

  function automatic int pairIndex(int i, int j);
    return i * NUM_SRC - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction
endpackage

// File: rtl/collCtrl.sv
module collCtrl
  import collPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              pixEn,
  input  logic              clrReq,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output collStrobes_t      strb,
  output logic [SEL_W-1:0]  regSel
);
  logic highZero;

  generate
    if (ADDR_W > SEL_W) begin : gWideAddr
      assign highZero = ~|rdAddr[ADDR_W-1:SEL_W];
    end else begin : gNarrowAddr
      assign highZero = 1'b1;
    end
  endgenerate

  assign regSel = rdAddr[SEL_W-1:0];

  always_comb begin
    strb.setEn    = pixEn;
    strb.clrAll   = clrReq;
    strb.rdLoad   = rdStrobe;
    strb.rdMapped = highZero;
  end
endmodule

// File: rtl/collDatapath.sv
module collDatapath
  import collPkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] gfxBits,
  input  collStrobes_t       strb,
  input  logic [SEL_W-1:0]   regSel,
  output logic [DATA_W-1:0]  rdData
);
  localparam int PAD_W = 2 * NUM_REGS;

  logic [NUM_PAIRS-1:0] pairHit;
  logic [NUM_PAIRS-1:0] pairLatch;
  logic [PAD_W-1:0]     padLatch;
  logic                 evenBit;
  logic                 oddBit;
  logic [1:0]           rdTop;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gRow
    for (genvar j = i + 1; j < NUM_SRC; j++) begin : gCol
      assign pairHit[pairIndex(i, j)] = gfxBits[i] & gfxBits[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pairLatch <= '0;
    else if (strb.clrAll)    pairLatch <= '0;
    else if (strb.setEn)     pairLatch <= pairLatch | pairHit;
  end

  generate
    if (PAD_W > NUM_PAIRS) begin : gPad
      assign padLatch = {{(PAD_W - NUM_PAIRS){1'b0}}, pairLatch};
    end else begin : gNoPad
      assign padLatch = pairLatch;
    end
  endgenerate

  always_comb begin
    evenBit = padLatch[{regSel, 1'b0}];
    oddBit  = padLatch[{regSel, 1'b1}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rdTop <= '0;
    else if (strb.rdLoad) rdTop <= strb.rdMapped ? {evenBit, oddBit} : 2'b00;
  end

  assign rdData = {rdTop, {(DATA_W - 2){1'b0}}};

  assert_set_on_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setEn && !strb.clrAll) |=> (($past(pairHit) & ~pairLatch) == '0));

  assert_no_set_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.setEn |=> ((pairLatch & ~$past(pairLatch)) == '0));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clrAll |=> (($past(pairLatch) & ~pairLatch) == '0));

  assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrAll |=> (pairLatch == '0));

  assert_clear_beats_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clrAll && strb.setEn && (|pairHit)) |=> (pairLatch == '0));

  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdLoad |=> $stable(rdData));

  assert_read_first_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdLoad && strb.rdMapped && regSel == '0) |=> (rdData[DATA_W-1] == $past(pairLatch[0])));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdLoad && !strb.rdMapped) |=> (rdData == '0));
endmodule

// File: rtl/collisionLatchArray.sv
module collisionLatchArray
  import collPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        gfxBits,
  input  logic              pixEn,
  input  logic              clrAll,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdStrobe,
  output logic [7:0]        rdData
);
  collStrobes_t     strb;
  logic [SEL_W-1:0] regSel;

  collCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .pixEn    (pixEn),
    .clrReq   (clrAll),
    .rdStrobe (rdStrobe),
    .rdAddr   (rdAddr),
    .strb     (strb),
    .regSel   (regSel)
  );

  collDatapath uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .gfxBits (gfxBits),
    .strb    (strb),
    .regSel  (regSel),
    .rdData  (rdData)
  );
endmodule

// File: tb/tb_collisionLatchArray.sv
module tb_collisionLatchArray;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] gfxBits;
  logic       pixEn;
  logic       clrAll;
  logic [3:0] rdAddr;
  logic       rdStrobe;
  logic [7:0] rdData;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  collisionLatchArray #(.ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .gfxBits(gfxBits), .pixEn(pixEn),
    .clrAll(clrAll), .rdAddr(rdAddr), .rdStrobe(rdStrobe), .rdData(rdData)
  );

  function automatic logic [14:0] pairsOf(logic [5:0] g);
    logic [14:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < 6; i++)
      for (int j = i + 1; j < 6; j++) begin
        r[k] = g[i] & g[j];
        k++;
      end
    return r;
  endfunction

  function automatic logic [7:0] expRead(logic [14:0] m, int a);
    logic [15:0] pm;
    pm = {1'b0, m};
    if (a >= 8) return 8'h00;
    return {pm[2*a], pm[2*a+1], 6'b0};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cycle(logic [5:0] g, logic pe, logic clr, logic rs, int a);
    gfxBits = g; pixEn = pe; clrAll = clr; rdStrobe = rs; rdAddr = 4'(a);
    @(posedge clk);
    @(negedge clk);
    gfxBits = '0; pixEn = 1'b0; clrAll = 1'b0; rdStrobe = 1'b0;
  endtask

  task automatic readAll(logic [14:0] m, string req);
    for (int a = 0; a < 16; a++) begin
      cycle(6'h00, 1'b0, 1'b0, 1'b1, a);
      if (a >= 8) check($sformatf("%s R9 addr %0d", req, a), rdData, 8'h00);
      else        check($sformatf("%s R7 addr %0d", req, a), rdData, expRead(m, a));
      check($sformatf("R8 addr %0d", a), {2'b00, rdData[5:0]}, 8'h00);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gfxBits = '0; pixEn = 1'b0; clrAll = 1'b0; rdStrobe = 1'b0; rdAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset rdData", rdData, 8'h00);
    rst_n = 1'b1;
    readAll(15'h0, "R10");

    // R1 R2: every stream pattern, one at a time
    for (int p = 0; p < 64; p++) begin
      cycle(6'h00, 1'b0, 1'b1, 1'b0, 0);
      cycle(6'(p), 1'b1, 1'b0, 1'b0, 0);
      readAll(pairsOf(6'(p)), "R1 R2");
    end

    // R3: overlap without pixel enable
    cycle(6'h00, 1'b0, 1'b1, 1'b0, 0);
    cycle(6'h3F, 1'b0, 1'b0, 1'b0, 0);
    readAll(15'h0, "R3");

    // R4: accumulation across cycles
    cycle(6'h03, 1'b1, 1'b0, 1'b0, 0);
    cycle(6'h30, 1'b1, 1'b0, 1'b0, 0);
    cycle(6'h00, 1'b1, 1'b0, 1'b0, 0);
    readAll(pairsOf(6'h03) | pairsOf(6'h30), "R4");

    // R5: clear alone
    cycle(6'h3F, 1'b1, 1'b0, 1'b0, 0);
    cycle(6'h00, 1'b0, 1'b1, 1'b0, 0);
    readAll(15'h0, "R5");

    // R6: clear and full overlap on the same edge
    cycle(6'h3F, 1'b1, 1'b0, 1'b0, 0);
    cycle(6'h3F, 1'b1, 1'b1, 1'b0, 0);
    readAll(15'h0, "R6");

    // R7: read on the setting edge sees the old state, then holds
    cycle(6'h03, 1'b1, 1'b0, 1'b1, 0);
    check("R7 read on set edge", rdData, 8'h00);
    cycle(6'h00, 1'b0, 1'b0, 1'b1, 0);
    check("R7 read after set", rdData, 8'h80);
    cycle(6'h00, 1'b0, 1'b0, 1'b0, 8);
    check("R7 hold without strobe", rdData, 8'h80);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule